// File: doc/BRIEF.md
# Path-Tag Forwarding Table

This block holds a table of forwarding entries that a host loads and inspects over a slow, asynchronous management bus, and that the cell datapath searches by tag. Each entry pairs a 12-bit path tag with a bitmap that has one bit per transmit port. The datapath presents the tag of an arriving cell. The block returns the bitmap of the entry that carries that tag, or all zeros when no entry carries it.

The host side uses a four-phase handshake with active-low lines for select, read strobe, write strobe and acknowledge. At rest the host keeps select and both strobes high. To start an access it puts the address (and the data, for a write) on the bus, pulls select low and then pulls one strobe low. The block performs the table access and then pulls acknowledge low. The host releases the strobe and select, and the block lets acknowledge go high again before the next access can start. The control lines pass through two-flop synchronisers before the state machine looks at them.

Top module: `fwd_tag_table`

## Requirements
- R1: After reset the acknowledge output is high, the read data output is zero, and a lookup of any tag returns a zero bitmap.
- R2: Acknowledge goes low only after the host has held select and a strobe low. It does not fall in the clock cycle in which the strobe is first driven low, because the control lines are synchronised.
- R3: A read returns the entry stored at the addressed location, and the read data is valid while acknowledge is low.
- R4: The entry layout on both data buses has the tag in bits [11:0] and the port bitmap in bits [15:12]. Bitmap bit k selects transmit port k.
- R5: One clock edge after a tag is presented, the lookup output holds the bitmap of the entry whose tag equals it.
- R6: A lookup whose tag matches no entry returns a zero bitmap.
- R7: When several entries hold the same tag, the entry with the lowest index decides the lookup result.
- R8: A strobe pulled low while select stays high is ignored. It produces no acknowledge and leaves the table unchanged.
- R9: Acknowledge stays low until the host has released select and both strobes, then returns high. Each handshake performs at most one table write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_ni | input | 1 | Host select, active low |
| host_rd_ni | input | 1 | Host read strobe, active low |
| host_wr_ni | input | 1 | Host write strobe, active low |
| host_addr_i | input | 8 | Table location addressed by the host |
| host_wdata_i | input | 16 | Entry to write: {bitmap, tag} |
| host_rdata_o | output | 16 | Entry read back: {bitmap, tag} |
| host_ack_no | output | 1 | Access acknowledge, active low |
| lookup_tag_i | input | 12 | Tag of the arriving cell |
| lookup_fwd_o | output | 4 | Port bitmap of the matching entry, or zero |

## Verification
The bound checker watches the handshake ordering on every cycle. Acknowledge may fall only after select and a strobe were seen low, and may rise only after all three lines were seen high. It must stay low while any of them is still held, and a table write is never followed directly by another write. The content-related behaviour can only be shown by the bench's scenarios: read-back of stored entries, the field layout, the lowest-index winner among duplicate tags, zero on a miss, and the fact that a strobe without select leaves the table untouched.

// File: rtl/fwd_tbl_pkg.sv
package fwd_tbl_pkg;
  parameter int TAG_W   = 12;
  parameter int PORTS   = 4;
  parameter int ENTRY_W = TAG_W + PORTS;

  typedef struct packed {
    logic [PORTS-1:0] fwd;
    logic [TAG_W-1:0] tag;
  } entry_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_HOLD = 2'd2
  } host_st_e;
endpackage

// File: rtl/fwd_sync.sv
module fwd_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fwd_host_ctrl.sv
module fwd_host_ctrl
  import fwd_tbl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sel_s_i,
  input  logic   rd_s_i,
  input  logic   wr_s_i,
  input  entry_t rd_entry_i,
  output logic   we_o,
  output logic   ack_no,
  output entry_t rdata_o
);
  host_st_e st_q;
  logic     wr_pend_q;
  logic     ack_q;
  entry_t   rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      wr_pend_q <= 1'b0;
      ack_q     <= 1'b1;
      rdata_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          // select must qualify either strobe
          if (!sel_s_i && (!wr_s_i || !rd_s_i)) begin
            wr_pend_q <= !wr_s_i;
            st_q      <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (!wr_pend_q) rdata_q <= rd_entry_i;
          ack_q <= 1'b0;
          st_q  <= ST_HOLD;
        end
        ST_HOLD: begin
          if (sel_s_i && rd_s_i && wr_s_i) begin
            ack_q     <= 1'b1;
            wr_pend_q <= 1'b0;
            st_q      <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign we_o    = (st_q == ST_XFER) && wr_pend_q;
  assign ack_no  = ack_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/fwd_tag_search.sv
module fwd_tag_search
  import fwd_tbl_pkg::*;
#(
  parameter int ENTRIES = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  entry_t           tbl_i [ENTRIES],
  input  logic [TAG_W-1:0] tag_i,
  output logic [PORTS-1:0] fwd_o
);
  logic [ENTRIES-1:0] hit;
  logic [PORTS-1:0]   fwd_d, fwd_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = (tbl_i[g].tag == tag_i);
  end

  // descending scan: lowest matching index is assigned last
  always_comb begin
    fwd_d = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) fwd_d = tbl_i[i].fwd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fwd_q <= '0;
    else         fwd_q <= fwd_d;
  end

  assign fwd_o = fwd_q;
endmodule

// File: rtl/fwd_tag_table.sv
module fwd_tag_table
  import fwd_tbl_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int ADDR_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_sel_ni,
  input  logic               host_rd_ni,
  input  logic               host_wr_ni,
  input  logic [ADDR_W-1:0]  host_addr_i,
  input  logic [ENTRY_W-1:0] host_wdata_i,
  output logic [ENTRY_W-1:0] host_rdata_o,
  output logic               host_ack_no,
  input  logic [TAG_W-1:0]   lookup_tag_i,
  output logic [PORTS-1:0]   lookup_fwd_o
);
  logic [2:0] ctl_s;
  logic       sel_s, rd_s, wr_s;
  logic       tbl_we;
  entry_t     tbl_q [ENTRIES];
  entry_t     rdata;

  fwd_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({host_sel_ni, host_rd_ni, host_wr_ni}),
    .q_o    (ctl_s)
  );
  assign {sel_s, rd_s, wr_s} = ctl_s;

  // address and data are held stable by the host until acknowledge
  fwd_host_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_s_i    (sel_s),
    .rd_s_i     (rd_s),
    .wr_s_i     (wr_s),
    .rd_entry_i (tbl_q[host_addr_i]),
    .we_o       (tbl_we),
    .ack_no     (host_ack_no),
    .rdata_o    (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
    end else if (tbl_we) begin
      tbl_q[host_addr_i] <= entry_t'(host_wdata_i);
    end
  end

  fwd_tag_search #(.ENTRIES(ENTRIES)) u_search (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tbl_i  (tbl_q),
    .tag_i  (lookup_tag_i),
    .fwd_o  (lookup_fwd_o)
  );

  assign host_rdata_o = rdata;
endmodule

// File: rtl/fwd_tag_table_chk.sv
module fwd_tag_table_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_s,
  input logic rd_s,
  input logic wr_s,
  input logic ack_no,
  input logic we
);
  // R2: acknowledge falls only after a qualified strobe was seen
  a_r2_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_no) |-> ($past(!sel_s) && ($past(!rd_s) || $past(!wr_s))));

  // R2: a table write follows a synchronised select plus write strobe
  a_r2_we_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> ($past(!sel_s) && $past(!wr_s)));

  // R9: acknowledge is held while the host still holds any line low
  a_r9_ack_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_no && !(sel_s && rd_s && wr_s)) |=> !ack_no);

  // R9: acknowledge rises only after full release
  a_r9_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_no) |-> $past(sel_s && rd_s && wr_s));

  // R9: one write per handshake
  a_r9_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> !we);
endmodule

bind fwd_tag_table fwd_tag_table_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_s  (sel_s),
  .rd_s   (rd_s),
  .wr_s   (wr_s),
  .ack_no (host_ack_no),
  .we     (tbl_we)
);

// File: tb/fwd_tag_table_tb.sv
module fwd_tag_table_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_ENT = 256;

  typedef struct packed {
    logic [7:0]  a;
    logic [11:0] t;
    logic [3:0]  f;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'd3,   12'h0A5, 4'b0011},
    '{8'd7,   12'h123, 4'b1000},
    '{8'd0,   12'hFFF, 4'b0101},
    '{8'd255, 12'h800, 4'b1111},
    '{8'd10,  12'h123, 4'b0110},
    '{8'd200, 12'h0A5, 4'b1100},
    '{8'd1,   12'h010, 4'b0001},
    '{8'd128, 12'h7FF, 4'b1010}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ack_n;
  logic [11:0] ltag = '0;
  logic [3:0]  lfwd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] model [N_ENT];

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_tag_table u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .host_sel_ni  (sel_n),
    .host_rd_ni   (rd_n),
    .host_wr_ni   (wr_n),
    .host_addr_i  (addr),
    .host_wdata_i (wdata),
    .host_rdata_o (rdata),
    .host_ack_no  (ack_n),
    .lookup_tag_i (ltag),
    .lookup_fwd_o (lfwd)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_fwd(input logic [11:0] t);
    for (int i = 0; i < N_ENT; i++)
      if (model[i][11:0] == t) return model[i][15:12];
    return 4'b0;
  endfunction

  task automatic wait_ack(input logic v, input string req);
    int n = 0;
    while (ack_n !== v && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'b0, ack_n}, {31'b0, v});
  endtask

  task automatic host_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; sel_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b0;
    @(negedge clk);
    chk("R2 ack not yet low", {31'b0, ack_n}, 32'd1);
    wait_ack(1'b0, "R2 ack low on write");
    wr_n = 1'b1; sel_n = 1'b1;
    wait_ack(1'b1, "R9 ack released");
    model[a] = d;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; sel_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b0;
    wait_ack(1'b0, "R3 ack low on read");
    d = rdata;
    rd_n = 1'b1; sel_n = 1'b1;
    wait_ack(1'b1, "R9 ack released");
  endtask

  task automatic lookup(input logic [11:0] t, input string req);
    @(negedge clk);
    ltag = t;
    @(negedge clk);
    chk(req, {28'b0, lfwd}, {28'b0, exp_fwd(t)});
  endtask

  initial begin
    logic [15:0] rd;
    for (int i = 0; i < N_ENT; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ack idle", {31'b0, ack_n}, 32'd1);
    chk("R1 rdata zero", {16'b0, rdata}, 32'd0);
    ltag = 12'h0A5;
    @(negedge clk);
    chk("R1 lookup zero", {28'b0, lfwd}, 32'd0);

    // vector table: write, read back, look up
    for (int v = 0; v < NV; v++) host_write(VEC[v].a, {VEC[v].f, VEC[v].t});
    for (int v = 0; v < NV; v++) begin
      host_read(VEC[v].a, rd);
      chk("R3 read back", {16'b0, rd}, {16'b0, model[VEC[v].a]});
      chk("R4 tag field", {20'b0, rd[11:0]}, {20'b0, VEC[v].t});
      chk("R4 bitmap field", {28'b0, rd[15:12]}, {28'b0, model[VEC[v].a][15:12]});
      lookup(VEC[v].t, "R5 lookup");
    end

    // R7 duplicates: index 3 beats 200, index 7 beats 10
    lookup(12'h0A5, "R7 lowest index 0A5");
    chk("R7 value 0A5", {28'b0, lfwd}, 32'b0011);
    lookup(12'h123, "R7 lowest index 123");
    chk("R7 value 123", {28'b0, lfwd}, 32'b1000);

    // R6 miss
    lookup(12'h555, "R6 miss");
    chk("R6 miss zero", {28'b0, lfwd}, 32'd0);

    // R8 strobe without select
    @(negedge clk);
    addr = 8'd3; wdata = 16'hFFFF; sel_n = 1'b1; wr_n = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R8 no ack", {31'b0, ack_n}, 32'd1);
    end
    wr_n = 1'b1;
    host_read(8'd3, rd);
    chk("R8 table unchanged", {16'b0, rd}, {16'b0, model[3]});

    // overwrite: old tag at index 3 gone, 0A5 now from index 200
    host_write(8'd3, {4'b0110, 12'h3C3});
    lookup(12'h0A5, "R5 after overwrite");
    chk("R7 fallback to 200", {28'b0, lfwd}, 32'b1100);
    lookup(12'h3C3, "R5 new tag");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule